// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is the target side of a two-wire serial memory (I2C-style) that serves reads only. It watches an SCL input and an open-drain SDA line, oversampled on the system clock. It recognises its own device byte by a fixed type nibble plus three strap pins. It answers with an acknowledge by pulling SDA low, and it shifts out bytes from an internal byte array.

A persistent address counter links transactions. A data-less write of two word-address bytes loads the counter. A read that follows, after a repeated start or a fresh start, returns the byte at the counter. Every byte shifted out advances the counter, and it wraps from the top of the array to zero. The master keeps a burst going by acknowledging each byte and ends it with a not-acknowledge and a stop.

A backdoor write port fills the array for test. The array depth is a parameter and must be a power of two.

Top module: `i2c_read_target`

## Requirements
- R1: A device byte is taken as ours only when bits 7..4 equal 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 selects the direction (1 = read, 0 = address load). The target then pulls SDA low during the ninth clock.
- R2: A device byte that differs in the type nibble or the strap bits gets no acknowledge. It leaves the address counter unchanged, and the target ignores the bus until the next start.
- R3: After a write-direction device byte, two bytes are received and each is acknowledged, high byte first. They load the address counter. Word-address bits at or above log2(DEPTH) are discarded.
- R4: A read-direction device byte makes the target return the byte stored at the address counter. The counter keeps its value between transactions, including across a stop.
- R5: The counter advances by one after each data byte has been shifted out, and it wraps from DEPTH-1 to 0.
- R6: Data leaves MSB first, and the SDA pull-low output changes only in response to an SCL falling edge, a start or a stop.
- R7: A master acknowledge (SDA low in the ninth clock of a read byte) starts the next sequential byte. A not-acknowledge ends the read, with SDA released.
- R8: A start or stop seen at any point resets the bit and byte sequencing. A start begins a new device byte, a stop returns to idle, and both release SDA.
- R9: A backdoor write (bd_we_i high on a clock edge) stores bd_data_i at bd_addr_i. The stored byte is what a later read of that address returns.
- R10: After reset SDA is released and the address counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Level of the shared data line |
| strap_i | input | 3 | Board strap bits compared against device byte bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| bd_we_i | input | 1 | Backdoor array write enable |
| bd_addr_i | input | log2(DEPTH) | Backdoor array address |
| bd_data_i | input | 8 | Backdoor array write data |

## Verification
The array is filled with an address-derived pattern, so a returned byte shows which location it came from. A wrong counter load, a missed advance or a lost wrap each appear as a distinct miscompare.

Directed cases cover several situations:
- a current read straight after reset;
- a load that ends in a stop, followed by a later read;
- bursts that cross the top of the array;
- word addresses with the high bits set;
- device bytes wrong in the type nibble or in the straps, where a following read must still see the old counter;
- a start that cuts into a half-sent byte.

Random rounds then mix address loads and bare current reads of random lengths. This separates counter persistence from counter loading.

// File: rtl/rdslave_pkg.sv
package rdslave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_HOLD
  } tgt_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // Device byte selects this target: type nibble and straps agree.
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
  endfunction

  // Read direction flag of a device byte.
  function automatic logic dev_is_read(input logic [7:0] b);
    return b[0];
  endfunction

endpackage

// File: rtl/rdslave_linemon.sv
module rdslave_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, scl_p, sda_q, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      scl_p <= 1'b1;
      sda_q <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= scl_i;
      scl_p <= scl_q;
      sda_q <= sda_i;
      sda_p <= sda_q;
    end
  end

  assign sda_lvl  = sda_q;
  assign ev_rise  = scl_q & ~scl_p;
  assign ev_fall  = ~scl_q & scl_p;
  assign ev_start = scl_q & scl_p & sda_p & ~sda_q;
  assign ev_stop  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/rdslave_store.sv
module rdslave_store #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rdslave_ctrl.sv
module rdslave_ctrl
  import rdslave_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic [2:0]    strap,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] addr_q,
  output logic          pull_q,
  output logic          adv_evt,
  output tgt_state_e    st_q
);
  tgt_state_e ack_to_q;
  logic [2:0] bitcnt_q;
  logic [7:0] sh_q, hi_q;
  logic       ack_on_q;
  logic [7:0] rx_byte;
  logic       last_bit;

  assign rx_byte  = {sh_q[6:0], sda_lvl};
  assign last_bit = (bitcnt_q == 3'd7);
  assign adv_evt  = (st_q == ST_RD) && ev_rise && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ack_to_q <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      hi_q     <= '0;
      addr_q   <= '0;
      pull_q   <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (ev_start) begin
      st_q     <= ST_DEV;
      bitcnt_q <= '0;
      pull_q   <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (ev_stop) begin
      st_q     <= ST_IDLE;
      bitcnt_q <= '0;
      pull_q   <= 1'b0;
      ack_on_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO: begin
          if (ev_rise) begin
            sh_q     <= rx_byte;
            bitcnt_q <= bitcnt_q + 3'd1;
            if (last_bit) begin
              if (st_q == ST_DEV) begin
                if (dev_hit(rx_byte, strap)) begin
                  st_q     <= ST_ACK;
                  ack_to_q <= dev_is_read(rx_byte) ? ST_RD : ST_AHI;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_AHI) begin
                hi_q     <= rx_byte;
                st_q     <= ST_ACK;
                ack_to_q <= ST_ALO;
              end else begin
                addr_q   <= AW'({hi_q, rx_byte});
                st_q     <= ST_ACK;
                ack_to_q <= ST_HOLD;
              end
            end
          end
        end
        ST_ACK: begin
          if (ev_fall) begin
            if (!ack_on_q) begin
              ack_on_q <= 1'b1;
              pull_q   <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              st_q     <= ack_to_q;
              bitcnt_q <= '0;
              if (ack_to_q == ST_RD) begin
                sh_q   <= rd_data;
                pull_q <= ~rd_data[7];
              end else begin
                pull_q <= 1'b0;
              end
            end
          end
        end
        ST_RD: begin
          if (ev_fall) pull_q <= ~sh_q[3'd7 - bitcnt_q];
          if (ev_rise) begin
            bitcnt_q <= bitcnt_q + 3'd1;
            if (last_bit) begin
              addr_q <= addr_q + AW'(1);
              st_q   <= ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (ev_fall) pull_q <= 1'b0;
          if (ev_rise) begin
            if (!sda_lvl) begin
              st_q     <= ST_RD;
              sh_q     <= rd_data;
              bitcnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_read_target.sv
module i2c_read_target
  import rdslave_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  output logic          sda_pull_o,
  input  logic          bd_we_i,
  input  logic [AW-1:0] bd_addr_i,
  input  logic [7:0]    bd_data_i
);
  logic          sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;
  logic [AW-1:0] addr_q;
  logic [7:0]    rd_data;
  logic          adv_evt;
  tgt_state_e    st_q;

  rdslave_linemon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  rdslave_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .wr_en(bd_we_i), .wr_addr(bd_addr_i), .wr_data(bd_data_i),
    .rd_addr(addr_q), .rd_data(rd_data)
  );

  rdslave_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop),
    .strap(strap_i), .rd_data(rd_data),
    .addr_q(addr_q), .pull_q(sda_pull_o), .adv_evt(adv_evt), .st_q(st_q)
  );
endmodule

// File: rtl/rdslave_chk.sv
module rdslave_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_rise,
  input logic          ev_fall,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          sda_pull_o,
  input logic [AW-1:0] addr_q,
  input logic          adv_evt
);
  // R6: the pull-low drive moves only after an SCL fall, a start or a stop
  assert_pull_moves_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> $past(ev_fall || ev_start || ev_stop));

  // R3: the counter is written only on an SCL rising edge
  assert_addr_moves_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> $past(ev_rise));

  // R5: one shifted-out byte moves the counter by exactly one, modulo the depth
  assert_advance_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (addr_q == AW'($past(addr_q) + AW'(1))));

  // R8: a stop leaves SDA released
  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull_o);

  // R8: a start leaves SDA released
  assert_start_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull_o);
endmodule

bind i2c_read_target rdslave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rise(ev_rise), .ev_fall(ev_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .sda_pull_o(sda_pull_o),
  .addr_q(addr_q), .adv_evt(adv_evt)
);

// File: tb/tb_i2c_read_target.sv
module tb_i2c_read_target;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_RD = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] DEV_WR = {4'b1010, STRAP, 1'b0};
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  logic sda_pull;
  logic sda_bus;
  int nvec = 0, nbad = 0, r6_bad = 0;
  int m_ctr = 0;
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  i2c_read_target #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .sda_pull_o(sda_pull), .bd_we_i(bd_we), .bd_addr_i(bd_addr), .bd_data_i(bd_data)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) ^ (a >> 2) ^ 8'h5A);
  endfunction

  function automatic int wrap(input int a);
    return a % DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 monitor: pull must not move while SCL has been high for two samples
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && (sda_pull != prev_pull)) r6_bad++;
    prev_scl  <= scl_m;
    prev_pull <= sda_pull;
  end

  task automatic tick();
    repeat (PH) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b0; tick();
    scl_m = 1'b0; tick();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick();
    scl_m = 1'b1; tick();
    sda_m = 1'b1; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick();
      scl_m = 1'b1; tick();
      scl_m = 1'b0; tick();
    end
    sda_m = 1'b1; tick();
    scl_m = 1'b1; tick();
    acked = (sda_bus == 1'b0);
    scl_m = 1'b0; tick();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      scl_m = 1'b1; tick();
      b = {b[6:0], sda_bus};
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick();
    scl_m = 1'b1; tick();
    scl_m = 1'b0; tick();
    sda_m = 1'b1;
  endtask

  // R3: address load (data-less write); leaves bus after second ack
  task automatic load_addr(input logic [15:0] w);
    bit a;
    do_start();
    send_byte(DEV_WR, a);
    chk(a, "R1 write device byte ack", a, 1);
    send_byte(w[15:8], a);
    chk(a, "R3 high address ack", a, 1);
    send_byte(w[7:0], a);
    chk(a, "R3 low address ack", a, 1);
    m_ctr = wrap(int'(w));
  endtask

  // R4/R5/R7: read n bytes; rep selects repeated start
  task automatic read_burst(input bit rep, input int n, input string tag);
    bit a;
    logic [7:0] got;
    if (rep) do_rstart(); else do_start();
    send_byte(DEV_RD, a);
    chk(a, "R1 read device byte ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      chk(got == pat(m_ctr), tag, got, pat(m_ctr));
      m_ctr = wrap(m_ctr + 1);
    end
    do_stop();
  endtask

  initial begin : main
    bit a;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R10: released after reset
    chk(sda_pull == 1'b0, "R10 pull released in reset", sda_pull, 0);
    rst_n = 1'b1;
    // R9: backdoor preload
    for (int i = 0; i < DEPTH; i++) begin
      bd_we = 1'b1; bd_addr = AW'(i); bd_data = pat(i);
      @(negedge clk);
    end
    bd_we = 1'b0;
    tick();
    chk(sda_pull == 1'b0, "R10 pull released after reset", sda_pull, 0);

    // R10/R4/R9: counter starts at zero
    m_ctr = 0;
    read_burst(1'b0, 1, "R10 first current read at zero");

    // R4/R5: counter persists and advanced
    read_burst(1'b0, 2, "R4 counter persists across stop");

    // R3/R7: random read with repeated start, sequential burst
    load_addr(16'h0011);
    read_burst(1'b1, 4, "R7 sequential burst");

    // R3: load ended by stop, later current read
    load_addr(16'h0020);
    do_stop();
    read_burst(1'b0, 1, "R3 load then stop then read");

    // R5: wrap from DEPTH-1 to 0
    load_addr(16'(DEPTH - 2));
    read_burst(1'b1, 5, "R5 wrap to zero");

    // R3: upper word-address bits discarded
    load_addr(16'hFF00 | 16'h0007);
    read_burst(1'b1, 2, "R3 upper address bits ignored");

    // R2: wrong straps, no ack, nothing further driven, counter untouched
    do_start();
    send_byte({4'b1010, ~STRAP, 1'b1}, a);
    chk(!a, "R2 strap mismatch not acked", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R2 stays idle after mismatch", a, 0);
    do_stop();
    do_start();
    send_byte({4'b1011, STRAP, 1'b0}, a);
    chk(!a, "R2 type mismatch not acked", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R2 no ack for following byte", a, 0);
    do_stop();
    read_burst(1'b0, 1, "R2 counter unchanged by mismatch");

    // R8: start in the middle of a byte restarts sequencing
    do_start();
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b0; tick();
      scl_m = 1'b1; tick();
      scl_m = 1'b0; tick();
    end
    chk(sda_pull == 1'b0, "R8 no drive during partial byte", sda_pull, 0);
    load_addr(16'h0005);
    read_burst(1'b1, 3, "R8 restart mid byte then read");

    // Random rounds: loads and current reads of random length
    for (int r = 0; r < 24; r++) begin
      int len;
      len = int'($urandom_range(1, 6));
      if ($urandom_range(0, 1) == 1) begin
        load_addr(16'($urandom_range(0, 65535)));
        read_burst(1'b1, len, "R5 random load and burst");
      end else begin
        read_burst(1'b0, len, "R4 random current read");
      end
    end

    chk(r6_bad == 0, "R6 pull moved while SCL high", r6_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule